// File: doc/BRIEF.md
# Time-Shared Dual-Port Memory

This block is a synchronous memory with one write port and one read port on a common clock. Behind the two ports sits a single-port storage array, used twice in every clock period. At the rising edge, both addresses, both strobes and the write data go into input registers. During the high half of the clock the array performs the write. During the low half it performs the read. An output register then takes the read word at the next rising edge and keeps it until another read replaces it.

The word count is a parameter, a power of two from 128 to 4096. The word width is a parameter, a multiple of 9 bits. The storage is divided into segments of 128 rows. Groups of four segments form a block of 512 words. The low seven address bits select the row. Address bits [8:7] select the column segment within a block. The bits above them select the block. Only the addressed segment is enabled during a phase, and every other segment stays idle. A cycle with no request starts no phase at all.

Top module: `tsdp_ram`

## Requirements
- R1: While `rst_ni` is low, and immediately after it is released, `rdata_o` is zero and `busy_o` is low.
- R2: A read requested in the cycle before edge N places the stored word on `rdata_o` just after edge N+1.
- R3: A write and a read to different addresses requested in the same cycle both complete in that one cycle. The write is stored, and the read returns the word that was stored before.
- R4: A write and a read to the same address in the same cycle return the new write data, because the write phase always runs before the read phase.
- R5: `rdata_o` changes only at an edge that ends a cycle containing a read phase. Write-only and idle cycles leave it unchanged.
- R6: `busy_o` is high for the whole cycle after any edge that captured a write or read request, and low after an edge that captured neither.
- R7: When no request is pending, no storage segment is enabled.
- R8: At most one storage segment is enabled at any time. The enabled segment is the one named by address bits [AW-1:7] of the address routed for the current phase.
- R9: Reset clears neither the input registers' effect on storage nor the storage itself. Words written before a reset read back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. The write phase runs while it is high, the read phase while it is low. |
| rst_ni | input | 1 | Active-low asynchronous reset. |
| we_i | input | 1 | Write request, captured at the rising edge. |
| waddr_i | input | AW | Write address. |
| wdata_i | input | DW | Write data, DW = 9*LANES. |
| re_i | input | 1 | Read request, captured at the rising edge. |
| raddr_i | input | AW | Read address. |
| rdata_o | output | DW | Read word, held until the next read. |
| busy_o | output | 1 | High while an access sequence is running. |

## Verification
The default configuration of 1024 words by 9 bits is swept in full three times. The first sweep writes every word on its own. The second sweep reads every word while writing its partner address, the one with bit 9 flipped, in the same cycle. Against the model, this shows whether segment and block decoding keep the two phases apart. The third sweep is read-only with a different data pattern, and it exposes any address bit that aliases between segments. Same-address write-and-read cycles distinguish write-first ordering from read-first ordering. Write-only and idle stretches placed after a read show whether the output register holds its value. A reset inserted in the middle of the run shows that the output clears while the stored words survive.

// File: rtl/tsdp_pkg.sv
package tsdp_pkg;
  localparam int ROW_W        = 7;
  localparam int SEG_ROWS     = 1 << ROW_W;
  localparam int SEGS_PER_BLK = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2
  } phase_e;
endpackage

// File: rtl/tsdp_phase_seq.sv
module tsdp_phase_seq
  import tsdp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_req_i,
  input  logic   rd_req_i,
  output phase_e phase_o
);
  logic p_tog, n_tog, first_half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_tog <= 1'b0;
    else         p_tog <= ~p_tog;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) n_tog <= 1'b0;
    else         n_tog <= p_tog;
  end

  // The two toggles differ from the rising edge to the falling edge.
  assign first_half = p_tog ^ n_tog;

  always_comb begin
    phase_o = PH_IDLE;
    if (first_half && wr_req_i)      phase_o = PH_WR;
    else if (!first_half && rd_req_i) phase_o = PH_RD;
  end
endmodule

// File: rtl/tsdp_sel_dec.sv
module tsdp_sel_dec
  import tsdp_pkg::*;
#(
  parameter int AW   = 10,
  parameter int NSEG = 8
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             active_i,
  output logic [ROW_W-1:0] row_o,
  output logic [NSEG-1:0]  seg_en_o
);
  localparam int NBLK = (NSEG + SEGS_PER_BLK - 1) / SEGS_PER_BLK;
  localparam int NCOL = (NSEG < SEGS_PER_BLK) ? NSEG : SEGS_PER_BLK;
  localparam int SW   = (NSEG > 1) ? $clog2(NSEG) : 1;

  logic [SW-1:0]   seg_idx;
  logic [NBLK-1:0] blk_sel;
  logic [NCOL-1:0] col_sel;

  assign row_o = addr_i[ROW_W-1:0];

  generate
    if (NSEG > 1) begin : g_multi
      assign seg_idx = addr_i[AW-1:ROW_W];
    end else begin : g_single
      assign seg_idx = '0;
    end
  endgenerate

  always_comb begin
    for (int b = 0; b < NBLK; b++)
      blk_sel[b] = active_i && (int'(seg_idx) / SEGS_PER_BLK == b);
    for (int c = 0; c < NCOL; c++)
      col_sel[c] = (int'(seg_idx) % SEGS_PER_BLK == c);
    for (int s = 0; s < NSEG; s++)
      seg_en_o[s] = blk_sel[s / SEGS_PER_BLK] & col_sel[s % SEGS_PER_BLK];
  end
endmodule

// File: rtl/tsdp_seg.sv
module tsdp_seg
  import tsdp_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] cells [SEG_ROWS];

  // The write phase ends at the falling edge.
  always_ff @(negedge clk_i) begin
    if (en_i && wr_i) cells[row_i] <= wdata_i;
  end

  assign rdata_o = en_i ? cells[row_i] : '0;
endmodule

// File: rtl/tsdp_ram.sv
module tsdp_ram
  import tsdp_pkg::*;
#(
  parameter int WORDS = 1024,
  parameter int LANES = 1,
  localparam int DW   = 9 * LANES,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o
);
  localparam int NSEG = WORDS / SEG_ROWS;

  logic             we_q, re_q;
  logic [AW-1:0]    wa_q, ra_q, mux_addr;
  logic [DW-1:0]    wd_q, rd_bus, rdata_q;
  logic [ROW_W-1:0] row;
  logic [NSEG-1:0]  seg_en;
  logic [DW-1:0]    seg_rd [NSEG];
  phase_e           phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      wa_q <= '0;
      ra_q <= '0;
      wd_q <= '0;
    end else begin
      we_q <= we_i;
      re_q <= re_i;
      wa_q <= waddr_i;
      ra_q <= raddr_i;
      wd_q <= wdata_i;
    end
  end

  tsdp_phase_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (we_q),
    .rd_req_i (re_q),
    .phase_o  (phase)
  );

  // Address multiplexer for the shared array.
  assign mux_addr = (phase == PH_RD) ? ra_q : wa_q;

  tsdp_sel_dec #(.AW(AW), .NSEG(NSEG)) u_dec (
    .addr_i   (mux_addr),
    .active_i (phase != PH_IDLE),
    .row_o    (row),
    .seg_en_o (seg_en)
  );

  generate
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      tsdp_seg #(.DW(DW)) u_seg (
        .clk_i   (clk_i),
        .en_i    (seg_en[s]),
        .wr_i    (phase == PH_WR),
        .row_i   (row),
        .wdata_i (wd_q),
        .rdata_o (seg_rd[s])
      );
    end
  endgenerate

  always_comb begin
    rd_bus = '0;
    for (int s = 0; s < NSEG; s++) rd_bus |= seg_rd[s];
  end

  // The output register captures the word at the rising edge that closes the read phase.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (phase == PH_RD)  rdata_q <= rd_bus;
  end

  assign rdata_o = rdata_q;
  assign busy_o  = we_q | re_q;

  p_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == $past(we_i || re_i));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_q |=> $stable(rdata_o));

  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> seg_en == '0);

  p_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(seg_en));

  p_onehot_neg_r8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $onehot0(seg_en));

  p_wr_first_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (we_q && re_q) |-> (phase == PH_WR));
endmodule

// File: tb/tsdp_ram_test.sv
module tsdp_ram_test;
  localparam int CLK_PERIOD = 10;
  localparam int QP         = CLK_PERIOD / 4;
  localparam int WORDS      = 1024;
  localparam int AW         = 10;
  localparam int DW         = 9;

  logic          clk, rst_n, we, re, busy;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rdata;

  tsdp_ram #(.WORDS(WORDS), .LANES(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .re_i(re), .raddr_i(raddr), .rdata_o(rdata), .busy_o(busy)
  );

  int            n_tests = 0, n_fail = 0;
  logic [DW-1:0] model [WORDS];
  logic [DW-1:0] pend_exp;
  bit            pend_v = 0;
  string         pend_tag;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one cycle of requests. Checks busy_o and the result of the read from the previous call.
  task automatic op(bit w, int wa, logic [DW-1:0] wd, bit r, int ra, string tag);
    logic [DW-1:0] prev_exp = pend_exp;
    bit            prev_v   = pend_v;
    string         prev_tag = pend_tag;
    we = w; waddr = AW'(wa); wdata = wd; re = r; raddr = AW'(ra);
    if (w) model[wa] = wd;
    pend_v = r;
    if (r) begin pend_exp = model[ra]; pend_tag = tag; end
    @(posedge clk); #QP;
    check("R6 busy", {8'd0, busy}, {8'd0, (w | r)});
    if (prev_v) check(prev_tag, rdata, prev_exp);
  endtask

  function automatic logic [DW-1:0] pat_a(int a);
    return DW'((a * 37 + 5) ^ (a >> 3));
  endfunction
  function automatic logic [DW-1:0] pat_b(int a);
    return DW'(((a & 1) != 0) ? 9'h155 ^ DW'(a >> 1) : 9'h0aa + DW'(a * 11));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    rst_n = 1'b0; we = 0; re = 0; waddr = '0; raddr = '0; wdata = '0;
    #(CLK_PERIOD * 2 + QP);
    check("R1 rdata in reset", rdata, '0);
    check("R1 busy in reset", {8'd0, busy}, 9'd0);
    rst_n = 1'b1;
    @(posedge clk); #QP;
    check("R1 rdata after release", rdata, '0);
    check("R1 busy after release", {8'd0, busy}, 9'd0);

    for (int a = 0; a < WORDS; a++) op(1, a, pat_a(a), 0, 0, "R2");
    // R3: write partner address while reading this one.
    for (int a = 0; a < WORDS; a++) op(1, a ^ 512, pat_b(a), 1, a, "R3 simultaneous");
    op(0, 0, '0, 0, 0, "");
    // R2: read-only sweep after rewriting with a fresh pattern.
    for (int a = 0; a < WORDS; a++) op(1, a, pat_b(a + 3), 0, 0, "R2");
    for (int a = 0; a < WORDS; a++) op(0, 0, '0, 1, a, "R2 read");
    op(0, 0, '0, 0, 0, "");

    // R4: same address written and read in one cycle.
    for (int a = 0; a < WORDS; a += 37) op(1, a, ~pat_a(a), 1, a, "R4 same address");
    op(0, 0, '0, 0, 0, "");

    // R5: the read result is held across write-only and idle cycles.
    op(0, 0, '0, 1, 300, "R5 read");
    op(0, 0, '0, 0, 0, "");
    held = model[300];
    for (int i = 0; i < 6; i++) begin
      op(1, (i * 171) % WORDS, DW'(i * 77 + 1), 0, 0, "");
      check("R5 hold after write", rdata, held);
    end
    op(0, 0, '0, 0, 0, "");
    check("R5 hold after idle", rdata, held);

    // R9: a reset in the middle of the run leaves storage intact.
    rst_n = 1'b0; pend_v = 0;
    #(CLK_PERIOD * 2);
    check("R1 rdata in reset", rdata, '0);
    check("R1 busy in reset", {8'd0, busy}, 9'd0);
    rst_n = 1'b1;
    @(posedge clk); #QP;
    for (int a = 1; a < WORDS; a += 101) op(0, 0, '0, 1, a, "R9 retained");
    op(0, 0, '0, 0, 0, "");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule